// File: doc/BRIEF.md
# Configurable Serial Shift Register

This block is a 32-bit shift register that software can load and read at any moment, paired with a 32-bit configuration word. The configuration word decides four things: which clock moves the register, what the serial output line carries, what enters the register on each shift, and which of 128 pin lines serve as clock, transmit and receive. The clock can come from one of two counter-generated clock levels, or from a chosen pin used as is or inverted.

Each active clock edge shifts the register one place toward the most significant end. The conditioned receive bit enters at bit 0, and bit 31 drives the outgoing line. Two instances of the block can be placed side by side. Each instance can then work as a transmitter, a receiver, or both at once. All pin inputs are synchronised before use. Framing, protocol handling and baud generation stay in software or elsewhere.

Data writes and configuration writes are plain strobes. They take effect on the next clock edge and are never refused, so this block applies no back-pressure.

Top module: `serial_shift_unit`

## Requirements
- R1: After reset the data register reads 0, the configuration is all zero, `tx_en` is 0 and `tx_bit` is 0.
- R2: A data write loads `data_wdata`, and `data_rdata` shows it from the next cycle on. No buffering or delay is involved.
- R3: Configuration bit 6 enables shifting. While it is 0, no clock edge changes the data register.
- R4: Clock mode bits [1:0] equal to 0 select counter clock A, and 1 selects counter clock B. The register shifts on the clock edge at which the selected counter level is first seen high. Edges on the other counter are ignored.
- R5: Clock mode 2 uses the pin indexed by bits [14:8] as is, and clock mode 3 uses it inverted. A change on that pin shifts the register at the third clock edge after the pin changes, because it passes a two-flop synchroniser and then an edge detector. Only a rising edge after the inversion counts.
- R6: A shift moves bits [30:0] up to [31:1] and puts the receive bit at bit 0. The unmodified serial output is bit 31, so data leaves MSB first.
- R7: Transmit mode bits [3:2] set `tx_bit`: 0 gives constant 0, 1 gives constant 1, 2 gives register bit 31, and 3 gives its inverse.
- R8: Receive mode bits [5:4] set the bit shifted in: 0 shifts in zeros, 1 shifts in ones, 2 takes the synchronised pin indexed by bits [30:24], and 3 takes that pin inverted.
- R9: Each pin select field is 7 bits wide and can address any of the 128 pin lines, from 0 to 127.
- R10: `tx_en` equals the enable bit. `tx_pin` equals the transmit pin field at bits [22:16].
- R11: If a data write and an active shift edge fall in the same cycle, the written value is stored and that shift is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctr_a_clk | input | 1 | Counter-generated clock level A |
| ctr_b_clk | input | 1 | Counter-generated clock level B |
| pin_in | input | 128 | Asynchronous pin input lines |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_data | input | 32 | Configuration word |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 32 | Value to load into the data register |
| data_rdata | output | 32 | Current data register contents |
| tx_bit | output | 1 | Conditioned serial output bit |
| tx_en | output | 1 | Output enable, equal to the enable bit |
| tx_pin | output | 7 | Index of the pin the output is meant for |

## Verification
The assertions assume that counter clock levels are synchronous to `clk`. They also assume that software changes the clock mode or clock pin only while shifting is disabled, so that switching sources cannot produce a false edge. The stimulus follows both rules. It writes every new configuration with the enable bit clear, moves the pins to their idle levels, waits for the synchroniser to settle, and only then enables the block. Receive pins are held steady for several cycles around each active edge, so the sampled bit is never taken during a pin transition.

// File: rtl/ssu_pkg.sv
package ssu_pkg;
  localparam int PIN_SEL_W = 7;
  localparam int PIN_W     = 1 << PIN_SEL_W;
  localparam int CFG_W     = 32;

  typedef enum logic [1:0] {
    CLK_CTR_A   = 2'd0,
    CLK_CTR_B   = 2'd1,
    CLK_PIN     = 2'd2,
    CLK_PIN_INV = 2'd3
  } clk_mode_e;

  typedef enum logic [1:0] {
    LINE_LOW  = 2'd0,
    LINE_HIGH = 2'd1,
    LINE_TRUE = 2'd2,
    LINE_INV  = 2'd3
  } line_mode_e;

  typedef struct packed {
    logic                 rsv3;
    logic [PIN_SEL_W-1:0] rx_pin;
    logic                 rsv2;
    logic [PIN_SEL_W-1:0] tx_pin;
    logic                 rsv1;
    logic [PIN_SEL_W-1:0] clk_pin;
    logic                 rsv0;
    logic                 enable;
    line_mode_e           rx_mode;
    line_mode_e           tx_mode;
    clk_mode_e            clk_mode;
  } cfg_word_t;

  function automatic logic apply_line_mode(line_mode_e m, logic v);
    case (m)
      LINE_LOW:  return 1'b0;
      LINE_HIGH: return 1'b1;
      LINE_TRUE: return v;
      default:   return ~v;
    endcase
  endfunction
endpackage

// File: rtl/ssu_pin_sync.sv
module ssu_pin_sync #(
  parameter int WIDTH  = 128,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) stage_q[s] <= '0;
      else if (s == 0) stage_q[s] <= async_in;
      else stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/ssu_clk_edge.sv
module ssu_clk_edge
  import ssu_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctr_a_clk,
  input  logic                 ctr_b_clk,
  input  logic [PIN_W-1:0]     pins_sync,
  input  logic [PIN_SEL_W-1:0] clk_pin,
  input  clk_mode_e            clk_mode,
  output logic                 shift_edge
);
  logic level;
  logic level_q;

  always_comb begin
    case (clk_mode)
      CLK_CTR_A:   level = ctr_a_clk;
      CLK_CTR_B:   level = ctr_b_clk;
      CLK_PIN:     level = pins_sync[clk_pin];
      default:     level = ~pins_sync[clk_pin];
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign shift_edge = level & ~level_q;

  // R4 R5: a rising edge can never be seen on two cycles in a row
  assert_single_edge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    shift_edge |=> !shift_edge);
endmodule

// File: rtl/ssu_shifter.sv
module ssu_shifter #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              shift_edge,
  input  logic              rx_bit,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)                   q <= '0;
    else if (wr)                  q <= wdata;
    else if (enable && shift_edge) q <= {q[DATA_W-2:0], rx_bit};
  end

  assert_write_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    wr |=> q == $past(wdata));

  assert_msb_first_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && enable && shift_edge) |=> q == {$past(q[DATA_W-2:0]), $past(rx_bit)});

  assert_hold_disabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr && !enable) |=> $stable(q));
endmodule

// File: rtl/serial_shift_unit.sv
module serial_shift_unit
  import ssu_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 ctr_a_clk,
  input  logic                 ctr_b_clk,
  input  logic [PIN_W-1:0]     pin_in,
  input  logic                 cfg_wr,
  input  logic [CFG_W-1:0]     cfg_data,
  input  logic                 data_wr,
  input  logic [DATA_W-1:0]    data_wdata,
  output logic [DATA_W-1:0]    data_rdata,
  output logic                 tx_bit,
  output logic                 tx_en,
  output logic [PIN_SEL_W-1:0] tx_pin
);
  cfg_word_t cfg_w;
  cfg_word_t cfg_q;
  logic      cfg_unused;
  logic [PIN_W-1:0] pins_sync;
  logic      shift_edge;
  logic      rx_bit;

  assign cfg_w = cfg_word_t'(cfg_data);

  always_ff @(posedge clk) begin
    if (!rst_n)      cfg_q <= '0;
    else if (cfg_wr) cfg_q <= cfg_w;
  end

  assign cfg_unused = ^{cfg_q.rsv0, cfg_q.rsv1, cfg_q.rsv2, cfg_q.rsv3};

  ssu_pin_sync #(.WIDTH(PIN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pin_in),
    .sync_out (pins_sync)
  );

  ssu_clk_edge u_edge (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctr_a_clk  (ctr_a_clk),
    .ctr_b_clk  (ctr_b_clk),
    .pins_sync  (pins_sync),
    .clk_pin    (cfg_q.clk_pin),
    .clk_mode   (cfg_q.clk_mode),
    .shift_edge (shift_edge)
  );

  assign rx_bit = apply_line_mode(cfg_q.rx_mode, pins_sync[cfg_q.rx_pin]);

  ssu_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (cfg_q.enable),
    .shift_edge (shift_edge),
    .rx_bit     (rx_bit),
    .wr         (data_wr),
    .wdata      (data_wdata),
    .q          (data_rdata)
  );

  assign tx_bit = apply_line_mode(cfg_q.tx_mode, data_rdata[DATA_W-1]);
  assign tx_en  = cfg_q.enable;
  assign tx_pin = cfg_q.tx_pin;

  // R10: the enable output follows a configuration write on the next cycle
  assert_enable_follows_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> tx_en == $past(cfg_data[6]));
endmodule

// File: tb/serial_shift_unit_test.sv
module serial_shift_unit_test;
  logic         clk = 0;
  logic         rst_n = 0;
  logic         ctr_a = 0, ctr_b = 0;
  logic [127:0] pins = '0;
  logic         cfg_wr = 0, data_wr = 0;
  logic [31:0]  cfg_data = '0, wdata = '0;
  logic [31:0]  rdata;
  logic         tx_bit, tx_en;
  logic [6:0]   tx_pin;
  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  serial_shift_unit uut (
    .clk(clk), .rst_n(rst_n), .ctr_a_clk(ctr_a), .ctr_b_clk(ctr_b),
    .pin_in(pins), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
    .data_wr(data_wr), .data_wdata(wdata), .data_rdata(rdata),
    .tx_bit(tx_bit), .tx_en(tx_en), .tx_pin(tx_pin));

  task automatic tick(int n = 1);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  task automatic chk(logic [31:0] got, logic [31:0] exp, string req);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] mk_cfg(bit en, int cm, int tm, int rm,
                                         int cp, int tp, int rp);
    logic [6:0] c = 7'(cp), t = 7'(tp), r = 7'(rp);
    return {1'b0, r, 1'b0, t, 1'b0, c, 1'b0, en, 2'(rm), 2'(tm), 2'(cm)};
  endfunction

  function automatic logic line(int m, logic v);
    return (m == 0) ? 1'b0 : (m == 1) ? 1'b1 : (m == 2) ? v : ~v;
  endfunction

  task automatic write_cfg(logic [31:0] c);
    cfg_data = c; cfg_wr = 1; tick(); cfg_wr = 0;
  endtask

  task automatic write_data(logic [31:0] d);
    wdata = d; data_wr = 1; tick(); data_wr = 0;
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, exp;
    logic        v, rxb;
    tick(3);
    rst_n = 1;
    tick();
    chk(rdata, 0, "R1 data");
    chk({31'b0, tx_bit}, 0, "R1 tx_bit");
    chk({31'b0, tx_en}, 0, "R1 tx_en");

    // Sweep of every clock, transmit and receive mode with varied pin selects
    for (int cm = 0; cm < 4; cm++)
      for (int rm = 0; rm < 4; rm++)
        for (int tm = 0; tm < 4; tm++) begin
          int combo = cm * 16 + rm * 4 + tm;
          int cp = (combo * 2) % 128;
          int rp = cp + 1;
          int tp = 127 - cp;
          write_cfg(mk_cfg(0, cm, tm, rm, cp, tp, rp));
          pins = '0;
          if (cm == 3) pins[cp] = 1'b1;
          v = combo[0] ^ combo[3];
          pins[rp] = v;
          tick(4);
          d = 32'h9E37_79B9 * (combo + 1);
          write_data(d);
          write_cfg(mk_cfg(1, cm, tm, rm, cp, tp, rp));
          tick();
          chk(rdata, d, "R3 no shift without edge");
          chk({31'b0, tx_bit}, {31'b0, line(tm, d[31])}, "R7 tx before");
          chk({25'b0, tx_pin}, tp, "R9 R10 tx_pin");
          chk({31'b0, tx_en}, 1, "R10 tx_en");
          rxb = line(rm, v);
          exp = {d[30:0], rxb};
          if (cm < 2) begin
            if (cm == 0) ctr_b = 1; else ctr_a = 1;
            tick(); ctr_a = 0; ctr_b = 0; tick();
            chk(rdata, d, "R4 other counter ignored");
            if (cm == 0) ctr_a = 1; else ctr_b = 1;
            tick();
            chk(rdata, exp, "R4 counter edge shift");
            ctr_a = 0; ctr_b = 0;
          end else begin
            pins[cp] = ~pins[cp];
            tick();
            chk(rdata, d, "R5 sync delay 1");
            tick();
            chk(rdata, d, "R5 sync delay 2");
            tick();
            chk(rdata, exp, "R5 pin edge shift R8");
            tick(2);
            pins[cp] = ~pins[cp];
          end
          tick(5);
          chk(rdata, exp, "R5 single shift per edge");
          chk({31'b0, tx_bit}, {31'b0, line(tm, exp[31])}, "R7 tx after");
        end

    // MSB-first stream of 32 bits in and out
    begin
      logic [31:0] p = 32'h5A0F_C396;
      d = 32'hC3A5_1E69;
      write_cfg(mk_cfg(0, 0, 2, 2, 0, 3, 50));
      write_data(d);
      write_cfg(mk_cfg(1, 0, 2, 2, 0, 3, 50));
      for (int i = 0; i < 32; i++) begin
        chk({31'b0, tx_bit}, {31'b0, d[31-i]}, "R6 tx order");
        pins[50] = p[31-i];
        tick(3);
        ctr_a = 1; tick(); ctr_a = 0; tick();
      end
      chk(rdata, p, "R6 R8 received word");
    end

    // Write coincident with a shift edge
    write_data(32'h1234_5678);
    wdata = 32'hDEAD_BEEF; data_wr = 1; ctr_a = 1;
    tick();
    data_wr = 0; ctr_a = 0;
    chk(rdata, 32'hDEAD_BEEF, "R11 write wins");
    tick(2);
    chk(rdata, 32'hDEAD_BEEF, "R11 shift discarded");

    // Disabled: counter and pin edges leave the register alone
    write_cfg(mk_cfg(0, 0, 1, 1, 127, 0, 0));
    chk({31'b0, tx_en}, 0, "R10 tx_en off");
    ctr_a = 1; tick(); ctr_a = 0; tick();
    chk(rdata, 32'hDEAD_BEEF, "R3 disabled counter");
    write_cfg(mk_cfg(0, 2, 1, 1, 127, 0, 0));
    pins[127] = 1; tick(5); pins[127] = 0; tick(5);
    chk(rdata, 32'hDEAD_BEEF, "R3 disabled pin");
    write_data(32'h0000_0001);
    chk(rdata, 1, "R2 write readback");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule